// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outgoing request path of a PCIe root complex. It turns an address from the on-chip interconnect into a PCIe bus address and a 32-bit actions word. The actions word carries the transaction type (memory, I/O, configuration or message) together with traffic class and attribute bits. Downstream logic decodes it; the translator itself passes it through unchanged.

A small register port programs a set of windows. Each window holds a 64-bit match value, a 64-bit remap value, a 64-bit mask and an actions word. A lookup compares the incoming address with every enabled window under that window's mask. On a hit, the masked bits of the address are replaced by the remap bits, and the window's actions word is returned. When no window hits, or when window mapping is switched off, the address passes through unchanged and a shared default actions word applies. The result is registered, so it appears one cycle after the request.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every configuration register reads 0, rsp_valid is 0, and a lookup misses with actions 0.
- R2: Window w owns a 32-byte register block at byte offset w*0x20. Its 32-bit slots are: match low at 0x00, match high at 0x04, remap low at 0x08, remap high at 0x0C, mask low at 0x10, mask high at 0x14, and actions at 0x18. A write to a slot is read back unchanged, except as stated in R3.
- R3: Mask bits below GRAN_BITS always read 0, whatever value is written. Windows are therefore at least 2^GRAN_BITS bytes, power-of-two sized and size-aligned.
- R4: The default actions word sits at offset 0x1C of the last window's block. Offset 0x1C of any other window reads 0 and ignores writes.
- R5: A window hits when map_en is 1, bit 0 of its match value is 1, and ((req_addr XOR match) AND mask) is 0.
- R6: On a hit, rsp_addr equals (remap AND mask) OR (req_addr AND NOT mask).
- R7: On a hit, rsp_hit is 1, rsp_win is the window number and rsp_actions is that window's actions word.
- R8: When several windows hit, the lowest-numbered one is used.
- R9: On a miss, or when map_en is 0, rsp_addr equals req_addr, rsp_hit is 0, rsp_win is 0 and rsp_actions is the default actions word.
- R10: rsp_valid equals req_valid one cycle earlier. Results appear one cycle after the request. The result outputs hold their values in any cycle that follows one without a request.
- R11: A window whose match bit 0 is 0 never hits, even when the address matches under its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_WIN)+3 (6) | Word address: byte offset bits [CFG_AW-1:2] |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| map_en | input | 1 | Global window mapping enable |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | 64 | Translated address |
| rsp_hit | output | 1 | A window hit |
| rsp_win | output | $clog2(NUM_WIN) (3) | Index of the hitting window |
| rsp_actions | output | 32 | Actions word of the hit window, or the default |

## Verification
The bench builds the block with NUM_WIN=4 and GRAN_BITS=4. With these values a window can be as small as 16 bytes, so an exhaustive sweep of the 256 lowest addresses crosses every window edge. That one sweep covers a nested overlap decided by priority, a disabled window, a wide remap and the unmapped gaps. The sweep is repeated twice: once with a high address bit set, which the masks then reject, and once with mapping switched off. The register map is read back slot by slot. This includes the truncated mask bits and the unused slot next to the default word.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int unsigned AW = 64;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    SL_MATCH_LO = 3'd0,
    SL_MATCH_HI = 3'd1,
    SL_REMAP_LO = 3'd2,
    SL_REMAP_HI = 3'd3,
    SL_MASK_LO  = 3'd4,
    SL_MASK_HI  = 3'd5,
    SL_ACTIONS  = 3'd6,
    SL_SPARE    = 3'd7
  } slot_e;
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned GRAN_BITS = 16,
  localparam int unsigned IDXW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned CFG_AW   = IDXW + 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:2]               cfg_addr,
  input  logic [DW-1:0]                   cfg_wdata,
  output logic [DW-1:0]                   cfg_rdata,
  output logic [NUM_WIN-1:0][AW-1:0]      win_match,
  output logic [NUM_WIN-1:0][AW-1:0]      win_remap,
  output logic [NUM_WIN-1:0][AW-1:0]      win_mask,
  output logic [NUM_WIN-1:0][DW-1:0]      win_act,
  output logic [DW-1:0]                   dflt_act
);
  localparam logic [DW-1:0]   GRAN_KEEP = {DW{1'b1}} << GRAN_BITS;
  localparam logic [IDXW-1:0] LAST_WIN  = IDXW'(NUM_WIN - 1);

  logic [IDXW-1:0] wi;
  slot_e           slot;

  assign wi   = cfg_addr[CFG_AW-1:5];
  assign slot = slot_e'(cfg_addr[4:2]);

  // per-window storage
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic          sel;
    logic [AW-1:0] m_q, m_d, r_q, r_d, k_q, k_d;
    logic [DW-1:0] a_q, a_d;

    assign sel = cfg_we && (wi == IDXW'(w));

    always_comb begin
      m_d = m_q;
      r_d = r_q;
      k_d = k_q;
      a_d = a_q;
      case (slot)
        SL_MATCH_LO: m_d[31:0]  = cfg_wdata;
        SL_MATCH_HI: m_d[63:32] = cfg_wdata;
        SL_REMAP_LO: r_d[31:0]  = cfg_wdata;
        SL_REMAP_HI: r_d[63:32] = cfg_wdata;
        SL_MASK_LO:  k_d[31:0]  = cfg_wdata & GRAN_KEEP;
        SL_MASK_HI:  k_d[63:32] = cfg_wdata;
        SL_ACTIONS:  a_d        = cfg_wdata;
        default:     ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '0;
        r_q <= '0;
        k_q <= '0;
        a_q <= '0;
      end else if (sel) begin
        m_q <= m_d;
        r_q <= r_d;
        k_q <= k_d;
        a_q <= a_d;
      end
    end

    assign win_match[w] = m_q;
    assign win_remap[w] = r_q;
    assign win_mask[w]  = k_q;
    assign win_act[w]   = a_q;
  end

  // default actions word, slot 7 of the last window block
  logic          dflt_we;
  logic [DW-1:0] dflt_q;

  assign dflt_we = cfg_we && (wi == LAST_WIN) && (slot == SL_SPARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dflt_q <= '0;
    else if (dflt_we) dflt_q <= cfg_wdata;
  end

  assign dflt_act = dflt_q;

  // read mux
  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (wi == IDXW'(w)) begin
        case (slot)
          SL_MATCH_LO: cfg_rdata = win_match[w][31:0];
          SL_MATCH_HI: cfg_rdata = win_match[w][63:32];
          SL_REMAP_LO: cfg_rdata = win_remap[w][31:0];
          SL_REMAP_HI: cfg_rdata = win_remap[w][63:32];
          SL_MASK_LO:  cfg_rdata = win_mask[w][31:0];
          SL_MASK_HI:  cfg_rdata = win_mask[w][63:32];
          SL_ACTIONS:  cfg_rdata = win_act[w];
          SL_SPARE:    cfg_rdata = (wi == LAST_WIN) ? dflt_q : '0;
          default:     cfg_rdata = '0;
        endcase
      end
    end
  end

  // R4: a write to a spare slot outside the last block leaves the default word alone
  a_r4_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && slot == SL_SPARE && wi != LAST_WIN) |=> $stable(dflt_act));
endmodule

// File: rtl/obwin_lookup.sv
module obwin_lookup
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned GRAN_BITS = 16,
  localparam int unsigned IDXW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       map_en,
  input  logic                       req_valid,
  input  logic [AW-1:0]              req_addr,
  input  logic [NUM_WIN-1:0][AW-1:0] win_match,
  input  logic [NUM_WIN-1:0][AW-1:0] win_remap,
  input  logic [NUM_WIN-1:0][AW-1:0] win_mask,
  input  logic [NUM_WIN-1:0][DW-1:0] win_act,
  input  logic [DW-1:0]              dflt_act,
  output logic                       rsp_valid,
  output logic [AW-1:0]              rsp_addr,
  output logic                       rsp_hit,
  output logic [IDXW-1:0]            rsp_win,
  output logic [DW-1:0]              rsp_actions
);
  logic [NUM_WIN-1:0] hitv;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hitv[w] = map_en && win_match[w][0] &&
                     (((req_addr ^ win_match[w]) & win_mask[w]) == '0);
  end

  logic            sel_hit;
  logic [IDXW-1:0] sel_idx;

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitv[w]) begin
        sel_hit = 1'b1;
        sel_idx = IDXW'(w);
      end
    end
  end

  logic [AW-1:0] addr_d, addr_q;
  logic [DW-1:0] act_d, act_q;
  logic          hit_q, vld_q;
  logic [IDXW-1:0] idx_q;

  always_comb begin
    if (sel_hit) begin
      addr_d = (win_remap[sel_idx] & win_mask[sel_idx]) |
               (req_addr & ~win_mask[sel_idx]);
      act_d  = win_act[sel_idx];
    end else begin
      addr_d = req_addr;
      act_d  = dflt_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      act_q  <= '0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        addr_q <= addr_d;
        act_q  <= act_d;
        hit_q  <= sel_hit;
        idx_q  <= sel_idx;
      end
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_addr    = addr_q;
  assign rsp_hit     = hit_q;
  assign rsp_win     = idx_q;
  assign rsp_actions = act_q;

  a_r10_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_actions)));
  a_r9_pass_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr)));
  a_r9_dflt_act: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_actions == $past(dflt_act)));
  a_r9_map_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_en) |=> !rsp_hit);
  a_r6_granule_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[GRAN_BITS-1:0] == $past(req_addr[GRAN_BITS-1:0])));
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned GRAN_BITS = 16,
  localparam int unsigned IDXW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned CFG_AW   = IDXW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:2] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              map_en,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic [63:0]       rsp_addr,
  output logic              rsp_hit,
  output logic [IDXW-1:0]   rsp_win,
  output logic [31:0]       rsp_actions
);
  logic [NUM_WIN-1:0][AW-1:0] win_match, win_remap, win_mask;
  logic [NUM_WIN-1:0][DW-1:0] win_act;
  logic [DW-1:0]              dflt_act;

  obwin_regs #(.NUM_WIN(NUM_WIN), .GRAN_BITS(GRAN_BITS)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win_match (win_match),
    .win_remap (win_remap),
    .win_mask  (win_mask),
    .win_act   (win_act),
    .dflt_act  (dflt_act)
  );

  obwin_lookup #(.NUM_WIN(NUM_WIN), .GRAN_BITS(GRAN_BITS)) i_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_en      (map_en),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .win_match   (win_match),
    .win_remap   (win_remap),
    .win_mask    (win_mask),
    .win_act     (win_act),
    .dflt_act    (dflt_act),
    .rsp_valid   (rsp_valid),
    .rsp_addr    (rsp_addr),
    .rsp_hit     (rsp_hit),
    .rsp_win     (rsp_win),
    .rsp_actions (rsp_actions)
  );
endmodule

// File: tb/test_obwin_xlate.sv
`timescale 1ns/1ps
module test_obwin_xlate;
  localparam int NW  = 4;
  localparam int GB  = 4;
  localparam int IW  = $clog2(NW);
  localparam int CAW = IW + 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [CAW-1:2]    cfg_addr;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic              map_en;
  logic              req_valid;
  logic [63:0]       req_addr;
  logic              rsp_valid;
  logic [63:0]       rsp_addr;
  logic              rsp_hit;
  logic [IW-1:0]     rsp_win;
  logic [31:0]       rsp_actions;

  always #2.5 clk = ~clk;

  obwin_xlate #(.NUM_WIN(NW), .GRAN_BITS(GB)) i_obwin_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .map_en(map_en),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_actions(rsp_actions)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] b_match [NW];
  logic [63:0] b_remap [NW];
  logic [63:0] b_mask  [NW];
  logic [31:0] b_act   [NW];
  logic [31:0] b_dflt;

  localparam logic [63:0] GCLR = ~((64'd1 << GB) - 64'd1);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = off[CAW-1:2];
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int off, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = off[CAW-1:2];
    #1;
    chk(tag, {32'd0, cfg_rdata}, {32'd0, exp});
  endtask

  task automatic prog(input int w, input logic [63:0] m, input logic [63:0] r,
                      input logic [63:0] k, input logic [31:0] a);
    wr(w*32 + 0,  m[31:0]);
    wr(w*32 + 4,  m[63:32]);
    wr(w*32 + 8,  r[31:0]);
    wr(w*32 + 12, r[63:32]);
    wr(w*32 + 16, k[31:0]);
    wr(w*32 + 20, k[63:32]);
    wr(w*32 + 24, a);
    b_match[w] = m;
    b_remap[w] = r;
    b_mask[w]  = k & GCLR;
    b_act[w]   = a;
  endtask

  task automatic lookup(input logic [63:0] a, input logic en);
    logic hit;
    int idx;
    logic [63:0] ea;
    logic [31:0] eact;
    string tag;
    @(negedge clk);
    map_en = en;
    req_valid = 1'b1;
    req_addr = a;
    hit = 1'b0;
    idx = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (en && b_match[w][0] && (((a ^ b_match[w]) & b_mask[w]) == 64'd0)) begin
        hit = 1'b1;
        idx = w;
      end
    ea   = hit ? ((b_remap[idx] & b_mask[idx]) | (a & ~b_mask[idx])) : a;
    eact = hit ? b_act[idx] : b_dflt;
    if (!en) tag = "R9";
    else if (hit && idx == 0 && (((a ^ b_match[1]) & b_mask[1]) == 64'd0)) tag = "R8";
    else if (hit) tag = "R6";
    else if (((a ^ b_match[2]) & b_mask[2]) == 64'd0) tag = "R11";
    else tag = "R9";
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", {63'd0, rsp_valid}, 64'd1);
    chk(tag, rsp_addr, ea);
    chk(hit ? "R5" : tag, {63'd0, rsp_hit}, {63'd0, hit});
    chk(hit ? "R7" : tag, {{(64-IW){1'b0}}, rsp_win}, 64'(idx));
    chk(hit ? "R7" : "R9", {32'd0, rsp_actions}, {32'd0, eact});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    map_en = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    for (int w = 0; w < NW; w++) begin
      b_match[w] = '0; b_remap[w] = '0; b_mask[w] = '0; b_act[w] = '0;
    end
    b_dflt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    for (int off = 0; off < NW*32; off += 4) rd_chk("R1", off, 32'd0);
    lookup(64'h55, 1'b1);

    // R2, R3: program and read back
    prog(0, 64'h0000_0000_0000_0051, 64'h1234_0000_0000_0380, 64'hFFFF_FFFF_FFFF_FFF7, 32'h0000_0810);
    prog(1, 64'h0000_0000_0000_0041, 64'h0000_0000_0000_0700, 64'hFFFF_FFFF_FFFF_FFC0, 32'h0000_0004);
    prog(2, 64'h0000_0000_0000_00A0, 64'h0000_0000_0000_0900, 64'hFFFF_FFFF_FFFF_FFE0, 32'h0000_0008);
    prog(3, 64'h0000_0000_0000_00C1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFE5, 32'h0000_000C);
    wr((NW-1)*32 + 28, 32'h0000_00A0);
    b_dflt = 32'h0000_00A0;
    for (int w = 0; w < NW; w++) begin
      rd_chk("R2", w*32 + 0,  b_match[w][31:0]);
      rd_chk("R2", w*32 + 4,  b_match[w][63:32]);
      rd_chk("R2", w*32 + 8,  b_remap[w][31:0]);
      rd_chk("R2", w*32 + 12, b_remap[w][63:32]);
      rd_chk("R3", w*32 + 16, b_mask[w][31:0]);
      rd_chk("R2", w*32 + 20, b_mask[w][63:32]);
      rd_chk("R2", w*32 + 24, b_act[w]);
    end
    rd_chk("R3", 16, 32'hFFFF_FFF0);

    // R4: spare slots
    rd_chk("R4", (NW-1)*32 + 28, 32'h0000_00A0);
    wr(28, 32'hDEAD_BEEF);
    rd_chk("R4", 28, 32'd0);
    rd_chk("R4", (NW-1)*32 + 28, 32'h0000_00A0);

    // sweeps
    for (int i = 0; i < 256; i++) lookup(64'(i), 1'b1);
    for (int i = 0; i < 256; i++) lookup(64'h0000_0100_0000_0000 | 64'(i), 1'b1);
    for (int i = 0; i < 256; i++) lookup(64'(i), 1'b0);

    // R10: outputs hold when idle
    lookup(64'h0000_0000_0000_00C7, 1'b1);
    held = rsp_addr;
    @(negedge clk);
    map_en = 1'b1;
    req_addr = 64'h0000_0000_0000_0045;
    @(negedge clk);
    chk("R10", {63'd0, rsp_valid}, 64'd0);
    chk("R10", rsp_addr, held);
    chk("R10", {32'd0, rsp_actions}, 64'h0000_000C);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule